// File: doc/BRIEF.md
# Five-Channel Compare/Capture Timer Array

This block is a shared 16-bit time base feeding five identical compare/capture channels. The time base advances on one of four selectable strobes: a fixed divide of the core clock by two or by four, a one-cycle overflow pulse from a neighbouring timer, or rising edges of an external clock pin. Each channel holds a 16-bit value split into a low and a high byte. A 3-bit mode byte gives the channel's job: latch the time base on an edge of its pin, raise an event when the time base steps onto its value, toggle its pin on that match, drive an 8-bit pulse-width output, or, on the last channel only, act as a watchdog.

Software reaches the block through a flat byte-wide register space. One address input serves both reads and writes, and the read port is combinational. Channel events land in sticky flags. The interrupt request is the OR of the flags whose enable bits are set. The external clock pin and the channel pins pass through two flip-flops before their edges are detected.

The time base has no state machine. The watchdog part of the last channel has two named states. `WD_WATCH` is the resting state. A compare match in watchdog mode causes the transition *trip* to `WD_FIRE`, where the reset output is held high. After the fixed pulse length, the transition *expire* returns the channel to `WD_WATCH`.

Top module: `ccu_array`

## Requirements
- R1: After reset the counter reads 0, all flags, enables and mode bytes are 0, every channel pin output is 0, and the interrupt and watchdog outputs are low.
- R2: Control register (address 2): bits [1:0] pick the time-base strobe (0 = clock/2, 1 = clock/4, 2 = overflow pulse input, 3 = external clock rising edge), and bit 2 enables counting. The counter steps by one per strobe and wraps from 0xFFFF to 0x0000. A strobe from a source that is not selected has no effect.
- R3: The external clock pin is synchronised through two flip-flops. Each of its rising edges advances the counter once when source 3 is selected.
- R4: The counter low byte (address 0) and high byte (address 1) can be written and read back. A write never counts as a step of the counter.
- R5: Capture modes (1 = rising pin edge, 2 = falling, 3 = either) copy the counter into the channel's low byte (address 16+2n) and high byte (address 17+2n) and set flag n. An edge of the other polarity changes nothing.
- R6: Mode 4 (timer) sets flag n in the cycle after the counter steps onto the channel's 16-bit value. Loading the counter directly to that value does not set it.
- R7: Mode 5 (toggle) inverts pin output n and sets flag n on such a match. The pin holds its level otherwise.
- R8: Mode 6 (PWM) drives pin n high while the counter low byte is below the channel's low byte, and low when it is equal or above.
- R9: In mode 6 the channel's low byte is reloaded from its high byte each time the counter low byte wraps to 0x00, so a new duty value takes effect only at the period boundary.
- R10: Mode 7 on channel 4 drives the watchdog reset high for exactly WDT_LEN (default 4) cycles after a match. Moving the compare value ahead of the counter before it arrives avoids the reset.
- R11: Flags (address 3, bit n = channel n) are cleared by writing 1s. A flag set in the same cycle as its clear stays set. The interrupt is high exactly when a flag with its enable bit (address 4) set is high.
- R12: Mode 0, and mode 7 on any channel but 4, leave the flag, pin and watchdog outputs untouched on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (5) | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tovf_i | input | 1 | One-cycle overflow pulse from a neighbouring timer |
| ext_clk_i | input | 1 | External counting clock, asynchronous |
| cex_i | input | NMOD (5) | Channel pins used for capture, asynchronous |
| cex_o | output | NMOD (5) | Channel pin outputs (toggle/PWM) |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A channel's match can set its flag in the very cycle that software writes a 1 to clear that flag. The test pulses the overflow input so that the counter steps onto the compare value. The clear write is timed for the next clock edge, where the flag update falls. The flag must read as set afterwards, and a later plain clear must bring it to 0.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;

    typedef enum logic [2:0] {
        MD_OFF      = 3'd0,
        MD_CAP_RISE = 3'd1,
        MD_CAP_FALL = 3'd2,
        MD_CAP_BOTH = 3'd3,
        MD_TIMER    = 3'd4,
        MD_TOGGLE   = 3'd5,
        MD_PWM      = 3'd6,
        MD_WDOG     = 3'd7
    } ccu_mode_e;

    typedef enum logic [1:0] {
        SRC_DIV2 = 2'd0,
        SRC_DIV4 = 2'd1,
        SRC_OVF  = 2'd2,
        SRC_EXT  = 2'd3
    } ccu_src_e;

    typedef enum logic {
        WD_WATCH = 1'b0,
        WD_FIRE  = 1'b1
    } wd_state_e;

    localparam int A_CNT_LO    = 0;
    localparam int A_CNT_HI    = 1;
    localparam int A_CTRL      = 2;
    localparam int A_FLAG      = 3;
    localparam int A_IEN       = 4;
    localparam int A_MODE_BASE = 8;
    localparam int A_REG_BASE  = 16;

endpackage

// File: rtl/ccu_sync.sv
`timescale 1ns/1ps
module ccu_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            lvl_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= d_i;
            lvl_o  <= meta_q;
            prev_o <= lvl_o;
        end
    end
endmodule

// File: rtl/ccu_timebase.sv
`timescale 1ns/1ps
module ccu_timebase
    import ccu_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  ccu_src_e    src_i,
    input  logic        run_i,
    input  logic        tovf_i,
    input  logic        ext_lvl_i,
    input  logic        ext_prev_i,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [7:0]  wdata_i,
    output logic [15:0] cnt_o,
    output logic        adv_o
);
    logic [1:0] pre_q;
    logic       strobe;
    logic       tick;
    logic       load;

    always_comb begin
        unique case (src_i)
            SRC_DIV2: strobe = pre_q[0];
            SRC_DIV4: strobe = &pre_q;
            SRC_OVF:  strobe = tovf_i;
            SRC_EXT:  strobe = ext_lvl_i & ~ext_prev_i;
        endcase
    end

    assign load = wr_lo_i | wr_hi_i;
    assign tick = run_i & strobe & ~load;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
            cnt_o <= '0;
            adv_o <= 1'b0;
        end else begin
            pre_q <= run_i ? pre_q + 2'd1 : 2'd0;
            adv_o <= tick;
            if (wr_lo_i) cnt_o[7:0]  <= wdata_i;
            if (wr_hi_i) cnt_o[15:8] <= wdata_i;
            if (tick)    cnt_o       <= cnt_o + 16'd1;
        end
    end
endmodule

// File: rtl/ccu_channel.sv
`timescale 1ns/1ps
module ccu_channel
    import ccu_pkg::*;
#(
    parameter bit WD_OK   = 1'b0,
    parameter int WDT_LEN = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] cnt_i,
    input  logic        adv_i,
    input  logic        pin_lvl_i,
    input  logic        pin_prev_i,
    input  logic        wr_mode_i,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [7:0]  wdata_i,
    output logic [2:0]  mode_o,
    output logic [15:0] val_o,
    output logic        pin_o,
    output logic        evt_o,
    output logic        wd_o
);
    localparam int RW = $clog2(WDT_LEN + 1);

    ccu_mode_e   mode_q;
    logic [7:0]  lo_q, hi_q;
    logic        pin_q, pin_nx;
    logic        hit, rise, fall;
    logic        cap_take, reload, wd_trip;
    logic [7:0]  lo_eff;
    wd_state_e   wd_q, wd_nx;
    logic [RW-1:0] run_q, run_nx;

    assign hit  = adv_i && (cnt_i == {hi_q, lo_q});
    assign rise = pin_lvl_i & ~pin_prev_i;
    assign fall = ~pin_lvl_i & pin_prev_i;

    // mode decode: events, pin next value, captures and reloads
    always_comb begin
        cap_take = 1'b0;
        reload   = 1'b0;
        wd_trip  = 1'b0;
        evt_o    = 1'b0;
        pin_nx   = pin_q;
        lo_eff   = lo_q;
        unique case (mode_q)
            MD_OFF:      ;
            MD_CAP_RISE: cap_take = rise;
            MD_CAP_FALL: cap_take = fall;
            MD_CAP_BOTH: cap_take = rise | fall;
            MD_TIMER:    evt_o = hit;
            MD_TOGGLE: begin
                evt_o  = hit;
                pin_nx = pin_q ^ hit;
            end
            MD_PWM: begin
                reload = adv_i && (cnt_i[7:0] == 8'h00);
                lo_eff = reload ? hi_q : lo_q;
                pin_nx = cnt_i[7:0] < lo_eff;
            end
            MD_WDOG: begin
                if (WD_OK) begin
                    evt_o   = hit;
                    wd_trip = hit;
                end
            end
        endcase
        if (cap_take) evt_o = 1'b1;
    end

    // watchdog next state
    always_comb begin
        wd_nx  = wd_q;
        run_nx = run_q;
        unique case (wd_q)
            WD_WATCH: begin
                run_nx = '0;
                if (wd_trip) wd_nx = WD_FIRE;
            end
            WD_FIRE: begin
                if (run_q == RW'(WDT_LEN - 1)) begin
                    wd_nx  = WD_WATCH;
                    run_nx = '0;
                end else begin
                    run_nx = run_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= MD_OFF;
            lo_q   <= '0;
            hi_q   <= '0;
            pin_q  <= 1'b0;
            wd_q   <= WD_WATCH;
            run_q  <= '0;
        end else begin
            if (wr_mode_i) mode_q <= ccu_mode_e'(wdata_i[2:0]);
            if (wr_lo_i)       lo_q <= wdata_i;
            else if (cap_take) lo_q <= cnt_i[7:0];
            else if (reload)   lo_q <= hi_q;
            if (wr_hi_i)       hi_q <= wdata_i;
            else if (cap_take) hi_q <= cnt_i[15:8];
            pin_q <= pin_nx;
            wd_q  <= wd_nx;
            run_q <= run_nx;
        end
    end

    assign mode_o = mode_q;
    assign val_o  = {hi_q, lo_q};
    assign pin_o  = pin_q;
    assign wd_o   = (wd_q == WD_FIRE);
endmodule

// File: rtl/ccu_array.sv
`timescale 1ns/1ps
module ccu_array
    import ccu_pkg::*;
#(
    parameter int NMOD    = 5,
    parameter int AW      = 5,
    parameter int WDT_LEN = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    input  logic            tovf_i,
    input  logic            ext_clk_i,
    input  logic [NMOD-1:0] cex_i,
    output logic [NMOD-1:0] cex_o,
    output logic            irq_o,
    output logic            wdt_rst_o
);
    ccu_src_e               src_q;
    logic                   run_q;
    logic [NMOD-1:0]        ien_q, flag_q, clr_w, evt_w, wd_w;
    logic [15:0]            cnt_w;
    logic                   adv_w;
    logic [NMOD:0]          lvl_w, prev_w;
    logic [NMOD-1:0][2:0]   mode_w;
    logic [NMOD-1:0][15:0]  val_w;

    ccu_sync #(.W(NMOD + 1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({ext_clk_i, cex_i}),
        .lvl_o  (lvl_w),
        .prev_o (prev_w)
    );

    ccu_timebase u_tb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_q),
        .run_i      (run_q),
        .tovf_i     (tovf_i),
        .ext_lvl_i  (lvl_w[NMOD]),
        .ext_prev_i (prev_w[NMOD]),
        .wr_lo_i    (wr_en_i && addr_i == AW'(A_CNT_LO)),
        .wr_hi_i    (wr_en_i && addr_i == AW'(A_CNT_HI)),
        .wdata_i    (wdata_i),
        .cnt_o      (cnt_w),
        .adv_o      (adv_w)
    );

    for (genvar n = 0; n < NMOD; n++) begin : g_ch
        ccu_channel #(.WD_OK(n == NMOD - 1), .WDT_LEN(WDT_LEN)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cnt_i      (cnt_w),
            .adv_i      (adv_w),
            .pin_lvl_i  (lvl_w[n]),
            .pin_prev_i (prev_w[n]),
            .wr_mode_i  (wr_en_i && addr_i == AW'(A_MODE_BASE + n)),
            .wr_lo_i    (wr_en_i && addr_i == AW'(A_REG_BASE + 2*n)),
            .wr_hi_i    (wr_en_i && addr_i == AW'(A_REG_BASE + 2*n + 1)),
            .wdata_i    (wdata_i),
            .mode_o     (mode_w[n]),
            .val_o      (val_w[n]),
            .pin_o      (cex_o[n]),
            .evt_o      (evt_w[n]),
            .wd_o       (wd_w[n])
        );
    end

    assign clr_w = (wr_en_i && addr_i == AW'(A_FLAG)) ? wdata_i[NMOD-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_q  <= SRC_DIV2;
            run_q  <= 1'b0;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en_i && addr_i == AW'(A_CTRL)) begin
                src_q <= ccu_src_e'(wdata_i[1:0]);
                run_q <= wdata_i[2];
            end
            if (wr_en_i && addr_i == AW'(A_IEN)) ien_q <= wdata_i[NMOD-1:0];
            flag_q <= (flag_q & ~clr_w) | evt_w;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(A_CNT_LO)) rdata_o = cnt_w[7:0];
        if (addr_i == AW'(A_CNT_HI)) rdata_o = cnt_w[15:8];
        if (addr_i == AW'(A_CTRL))   rdata_o = {5'd0, run_q, src_q};
        if (addr_i == AW'(A_FLAG))   rdata_o = 8'(flag_q);
        if (addr_i == AW'(A_IEN))    rdata_o = 8'(ien_q);
        for (int n = 0; n < NMOD; n++) begin
            if (addr_i == AW'(A_MODE_BASE + n))       rdata_o = {5'd0, mode_w[n]};
            if (addr_i == AW'(A_REG_BASE + 2*n))      rdata_o = val_w[n][7:0];
            if (addr_i == AW'(A_REG_BASE + 2*n + 1))  rdata_o = val_w[n][15:8];
        end
    end

    assign irq_o     = |(flag_q & ien_q);
    assign wdt_rst_o = |wd_w;
endmodule

// File: rtl/ccu_array_chk.sv
`timescale 1ns/1ps
module ccu_array_chk
    import ccu_pkg::*;
#(
    parameter int NMOD = 5,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [15:0]     cnt,
    input logic [NMOD-1:0] flags,
    input logic            irq,
    input logic            wdt,
    input logic [2:0]      mode4
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(wr_en && (addr == AW'(A_CNT_LO) || addr == AW'(A_CNT_HI))))
        |-> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) != '0) |-> $past(wr_en && addr == AW'(A_FLAG))); // R11

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flags != '0)); // R11

    AST_WDT_ONLY_MOD4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt) |-> ($past(mode4) == 3'd7)); // R10

    AST_WDT_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt) |=> wdt); // R10
endmodule

bind ccu_array ccu_array_chk #(.NMOD(NMOD), .AW(AW)) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .wr_en (wr_en_i),
    .addr  (addr_i),
    .cnt   (cnt_w),
    .flags (flag_q),
    .irq   (irq_o),
    .wdt   (wdt_rst_o),
    .mode4 (mode_w[NMOD-1])
);

// File: tb/ccu_array_test.sv
`timescale 1ns/1ps
module ccu_array_test;
    localparam int NMOD = 5;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            tovf = 1'b0;
    logic            ext = 1'b0;
    logic [NMOD-1:0] cex_in = '0;
    logic [NMOD-1:0] cex_out;
    logic            irq, wdt;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ccu_array #(.NMOD(NMOD), .AW(AW), .WDT_LEN(4)) uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tovf_i(tovf), .ext_clk_i(ext),
        .cex_i(cex_in), .cex_o(cex_out), .irq_o(irq), .wdt_rst_o(wdt)
    );

    // {counter preload, compare value, expected flag}
    localparam logic [32:0] VEC [0:5] = '{
        {16'h0009, 16'h000A, 1'b1},
        {16'h0009, 16'h000B, 1'b0},
        {16'hFFFF, 16'h0000, 1'b1},
        {16'h00FF, 16'h0100, 1'b1},
        {16'h1234, 16'h1234, 1'b0},
        {16'h7FFE, 16'h7FFF, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        addr = AW'(a);
        #0.5;
        d = rdata;
    endtask

    task automatic rd16(input int a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 1, hi);
        d = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(0, v[7:0]);
        wr(1, v[15:8]);
    endtask

    task automatic set_val(input int ch, input logic [15:0] v);
        wr(16 + 2*ch, v[7:0]);
        wr(17 + 2*ch, v[15:8]);
    endtask

    task automatic step;
        @(negedge clk); tovf = 1'b1;
        @(negedge clk); tovf = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int          n;

        wait_cyc(4);
        // R1 reset state
        rd(0, b); chk("R1 counter low", b, 8'h00);
        rd(3, b); chk("R1 flags", b, 8'h00);
        rd(8 + 4, b); chk("R1 mode byte", b, 8'h00);
        chk("R1 pins", cex_out, 0);
        chk("R1 irq/wdt", {irq, wdt}, 0);
        rst_n = 1'b1;
        wait_cyc(1);

        // R4 counter access, overflow source selected and running
        wr(2, 8'h06);
        set_cnt(16'h1234);
        rd16(0, w); chk("R4 counter readback", w, 16'h1234);

        // R6 / R11 vector table: channel 0 in timer mode, interrupt enabled
        wr(8, 8'h04);
        wr(4, 8'h01);
        for (int i = 0; i < 6; i++) begin
            set_cnt(VEC[i][32:17]);
            set_val(0, VEC[i][16:1]);
            wr(3, 8'h1F);
            step();
            rd(3, b);
            chk($sformatf("R6 timer flag row %0d", i), b[0], VEC[i][0]);
            chk($sformatf("R11 irq row %0d", i), irq, VEC[i][0]);
        end

        // R11 set beats clear in the same cycle
        set_cnt(16'h0009);
        set_val(0, 16'h000A);
        wr(3, 8'h1F);
        @(negedge clk); tovf = 1'b1;
        @(negedge clk); tovf = 1'b0; wr_en = 1'b1; addr = AW'(3); wdata = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rd(3, b); chk("R11 set wins over clear", b[0], 1'b1);
        wr(4, 8'h00);
        chk("R11 irq masked", irq, 1'b0);
        wr(3, 8'h01);
        rd(3, b); chk("R11 write-1 clear", b[0], 1'b0);

        // R7 toggle mode on channel 2
        wr(10, 8'h05);
        set_val(2, 16'h0003);
        set_cnt(16'h0002);
        step();
        chk("R7 pin toggles high", cex_out[2], 1'b1);
        rd(3, b); chk("R7 flag", b[2], 1'b1);
        step();
        chk("R7 pin holds", cex_out[2], 1'b1);
        set_cnt(16'h0002);
        step();
        chk("R7 pin toggles low", cex_out[2], 1'b0);

        // R12 watchdog mode on a channel other than 4 has no effect
        wr(11, 8'h07);
        set_val(3, 16'h0011);
        set_cnt(16'h0010);
        wr(3, 8'h1F);
        step();
        rd(3, b); chk("R12 no flag", b[3], 1'b0);
        chk("R12 no pin/wdt", {cex_out[3], wdt}, 0);

        // R8 / R9 PWM on channel 1
        wr(9, 8'h06);
        set_val(1, 16'h0202);
        set_cnt(16'h0000);
        wait_cyc(1);
        chk("R8 pwm high below", cex_out[1], 1'b1);
        step();
        chk("R8 pwm high at 1", cex_out[1], 1'b1);
        step();
        chk("R8 pwm low at equal", cex_out[1], 1'b0);
        wr(17 + 2, 8'h05);
        step();
        chk("R9 no mid-period change", cex_out[1], 1'b0);
        set_cnt(16'h00FF);
        wait_cyc(1);
        step();
        chk("R9 new duty after wrap", cex_out[1], 1'b1);
        step();
        rd(16 + 2, b); chk("R9 low byte reloaded", b, 8'h05);
        chk("R8 pwm high at 0x0101", cex_out[1], 1'b1);

        // R5 capture on channel 0
        wr(8, 8'h01);
        set_cnt(16'h0ABC);
        wr(3, 8'h1F);
        cex_in[0] = 1'b1; wait_cyc(5);
        rd16(16, w); chk("R5 rise capture value", w, 16'h0ABC);
        rd(3, b); chk("R5 rise capture flag", b[0], 1'b1);
        wr(3, 8'h1F);
        set_cnt(16'h0DEF);
        cex_in[0] = 1'b0; wait_cyc(5);
        rd16(16, w); chk("R5 fall ignored in rise mode", w, 16'h0ABC);
        rd(3, b); chk("R5 no flag on fall", b[0], 1'b0);
        wr(8, 8'h03);
        set_cnt(16'h0222);
        cex_in[0] = 1'b1; wait_cyc(5);
        rd16(16, w); chk("R5 both-edge rise", w, 16'h0222);
        set_cnt(16'h0333);
        cex_in[0] = 1'b0; wait_cyc(5);
        rd16(16, w); chk("R5 both-edge fall", w, 16'h0333);

        // R10 watchdog on channel 4
        set_val(4, 16'h0005);
        wr(12, 8'h07);
        set_cnt(16'h0003);
        step();
        set_val(4, 16'h0008);
        step();
        chk("R10 rewrite avoids reset", wdt, 1'b0);
        set_cnt(16'h0007);
        step();
        chk("R10 reset asserted", wdt, 1'b1);
        n = 0;
        while (wdt && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk("R10 reset length", n, 4);

        // R2 divided clock sources
        wr(2, 8'h00);
        set_cnt(16'h0000);
        wr(2, 8'h04);
        wait_cyc(40);
        rd16(0, w); chk("R2 div2 count", w, 16'd20);
        wr(2, 8'h00);
        set_cnt(16'h0000);
        wr(2, 8'h05);
        wait_cyc(40);
        rd16(0, w); chk("R2 div4 count", w, 16'd10);

        // R3 external clock
        wr(2, 8'h03);
        set_cnt(16'h0000);
        wr(2, 8'h07);
        for (int k = 0; k < 3; k++) begin
            ext = 1'b1; wait_cyc(4);
            ext = 1'b0; wait_cyc(4);
        end
        rd16(0, w); chk("R3 external edges counted", w, 16'd3);
        step();
        rd16(0, w); chk("R2 unselected overflow ignored", w, 16'd3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule